// File: doc/BRIEF.md
# General-Purpose Pin Port with Atomic Output Updates

This block drives a port of 32 pins from a small memory-mapped register set. Software can load an output data word directly, or change individual pins without first reading the word back. To do that it writes a mask to a set, clear or toggle register, and each one in the mask raises, lowers or inverts the matching output pin. A direction word decides, pin by pin, whether the output driver is enabled.

Pin levels coming back from the pads pass through a two-flop synchronizer and can then be read from an input register. The register interface is a plain valid/write/address/data port. Writes take effect on the clock edge that samples them. Read data is combinational and is returned in the same cycle as the request.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset the output data word and the direction word are zero, so `pin_out` and `pin_oe` are all zero and every pin is an input.
- R2: A write to offset 0x00 loads the output data word; `pin_out` shows the new value after that clock edge, and a read of 0x00 returns it.
- R3: A write to offset 0x04 drives high each output bit where the written word has a one; bits written as zero keep their value.
- R4: A write to offset 0x08 drives low each output bit where the written word has a one; the other bits keep their value.
- R5: A write to offset 0x0C inverts each output bit where the written word has a one; the other bits keep their value.
- R6: A read of offset 0x10 returns the pin levels after a two-flop synchronizer. A pin change made before one clock edge is not visible after that edge, and is visible after the next edge. Writes to 0x10 change nothing.
- R7: Offset 0x14 holds the direction word. Bit n = 1 enables the output driver (`pin_oe[n]`) and bit n = 0 makes pin n an input. The word reads back unchanged.
- R8: Reads of 0x04, 0x08 and 0x0C return zero. Any address other than 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14 reads as zero, and a write to it changes no state. Addresses that are not multiples of four are counted among these.
- R9: `bus_rdata` is zero in every cycle that is not a read request (`bus_valid` low, or `bus_write` high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| pin_in | input | 32 | Pin levels from the pads (asynchronous) |
| pin_out | output | 32 | Output data to the pads |
| pin_oe | output | 32 | Output driver enable per pin |

## Verification
Two functions can meet in one cycle: a pin changes level while software reads the input register. The bench changes `pin_in` and reads 0x10 just after the next edge and again after the one after it. It expects the previous pattern on the first read and the new pattern on the second. It also issues every write while watching `bus_rdata`, and expects zero there, because a write cycle must never be mistaken for a read.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [2:0] {
    SEL_DATA,
    SEL_SET,
    SEL_CLR,
    SEL_TGL,
    SEL_IN,
    SEL_DIR,
    SEL_NONE
  } reg_sel_e;

  localparam logic [31:0] OFF_DATA = 32'h00;
  localparam logic [31:0] OFF_SET  = 32'h04;
  localparam logic [31:0] OFF_CLR  = 32'h08;
  localparam logic [31:0] OFF_TGL  = 32'h0C;
  localparam logic [31:0] OFF_IN   = 32'h10;
  localparam logic [31:0] OFF_DIR  = 32'h14;

  // Maps a byte offset to a register; misaligned or unknown offsets map to none.
  function automatic reg_sel_e decode_offset(input logic [31:0] off);
    reg_sel_e s;
    case (off)
      OFF_DATA: s = SEL_DATA;
      OFF_SET:  s = SEL_SET;
      OFF_CLR:  s = SEL_CLR;
      OFF_TGL:  s = SEL_TGL;
      OFF_IN:   s = SEL_IN;
      OFF_DIR:  s = SEL_DIR;
      default:  s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
  import gpio_port_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic              wr_data,
  output logic              wr_set,
  output logic              wr_clr,
  output logic              wr_tgl,
  output logic              wr_dir,
  output logic              rd_req
);

  logic [31:0] addr_ext;
  logic        wr_req;

  assign addr_ext = 32'(addr);
  assign sel      = decode_offset(addr_ext);
  assign wr_req   = valid & write;
  assign rd_req   = valid & ~write;

  assign wr_data = wr_req & (sel == SEL_DATA);
  assign wr_set  = wr_req & (sel == SEL_SET);
  assign wr_clr  = wr_req & (sel == SEL_CLR);
  assign wr_tgl  = wr_req & (sel == SEL_TGL);
  assign wr_dir  = wr_req & (sel == SEL_DIR);

  // R8: at most one register strobe per cycle; unmapped writes give none
  p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_data, wr_set, wr_clr, wr_tgl, wr_dir}));

  p_no_rw_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> !(wr_data | wr_set | wr_clr | wr_tgl | wr_dir));

endmodule

// File: rtl/gpio_out_reg.sv
module gpio_out_reg #(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_data,
  input  logic                wr_set,
  input  logic                wr_clr,
  input  logic                wr_tgl,
  input  logic [NUM_PINS-1:0] wdata,
  output logic [NUM_PINS-1:0] q
);

  // Load first, then set, clear and toggle, in that order.
  function automatic logic [NUM_PINS-1:0] apply_ops(
    input logic [NUM_PINS-1:0] cur,
    input logic                ld,
    input logic [NUM_PINS-1:0] ld_val,
    input logic [NUM_PINS-1:0] set_m,
    input logic [NUM_PINS-1:0] clr_m,
    input logic [NUM_PINS-1:0] tgl_m
  );
    logic [NUM_PINS-1:0] v;
    v = ld ? ld_val : cur;
    v = v | set_m;
    v = v & ~clr_m;
    v = v ^ tgl_m;
    return v;
  endfunction

  logic [NUM_PINS-1:0] set_mask, clr_mask, tgl_mask, q_next;

  assign set_mask = wr_set ? wdata : '0;
  assign clr_mask = wr_clr ? wdata : '0;
  assign tgl_mask = wr_tgl ? wdata : '0;
  assign q_next   = apply_ops(q, wr_data, wdata, set_mask, clr_mask, tgl_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> q == $past(wdata));

  p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((q & $past(wdata)) == $past(wdata)) &&
               ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata))));

  p_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((q & $past(wdata)) == '0) &&
               ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata))));

  p_tgl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tgl |=> (q ^ $past(q)) == $past(wdata));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_data | wr_set | wr_clr | wr_tgl) |=> $stable(q));

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned STAGES   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] d,
  output logic [NUM_PINS-1:0] q
);

  localparam int unsigned WARM_W = $clog2(STAGES + 1);

  logic [NUM_PINS-1:0] stg [STAGES];
  logic [WARM_W-1:0]   warm;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];

  // Counts edges since reset so the latency check never looks before reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       warm <= '0;
    else if (warm != WARM_W'(STAGES)) warm <= warm + 1'b1;
  end

  if (STAGES == 2) begin : g_lat_chk
    p_lag_two_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (warm == WARM_W'(STAGES)) |-> q == $past(d, 2));
  end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_valid,
  input  logic                bus_write,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [NUM_PINS-1:0] bus_wdata,
  output logic [NUM_PINS-1:0] bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe
);

  reg_sel_e            sel;
  logic                wr_data, wr_set, wr_clr, wr_tgl, wr_dir, rd_req;
  logic [NUM_PINS-1:0] in_sync;
  logic [NUM_PINS-1:0] dir_q;

  gpio_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid   (bus_valid),
    .write   (bus_write),
    .addr    (bus_addr),
    .sel     (sel),
    .wr_data (wr_data),
    .wr_set  (wr_set),
    .wr_clr  (wr_clr),
    .wr_tgl  (wr_tgl),
    .wr_dir  (wr_dir),
    .rd_req  (rd_req)
  );

  gpio_out_reg #(.NUM_PINS(NUM_PINS)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_data (wr_data),
    .wr_set  (wr_set),
    .wr_clr  (wr_clr),
    .wr_tgl  (wr_tgl),
    .wdata   (bus_wdata),
    .q       (pin_out)
  );

  gpio_in_sync #(.NUM_PINS(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (in_sync)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '0;
    else if (wr_dir) dir_q <= bus_wdata;
  end

  assign pin_oe = dir_q;

  always_comb begin
    bus_rdata = '0;
    if (rd_req) begin
      case (sel)
        SEL_DATA: bus_rdata = pin_out;
        SEL_IN:   bus_rdata = in_sync;
        SEL_DIR:  bus_rdata = dir_q;
        default:  bus_rdata = '0;
      endcase
    end
  end

  p_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> pin_oe == $past(bus_wdata));

  p_dir_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dir |=> $stable(pin_oe));

  p_idle_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |-> bus_rdata == '0);

  p_wo_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write &&
     (bus_addr == ADDR_W'(4) || bus_addr == ADDR_W'(8) || bus_addr == ADDR_W'(12)))
    |-> bus_rdata == '0);

endmodule

// File: tb/tb_gpio_port_regs.sv
module tb_gpio_port_regs;

  localparam int N = 32;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_valid = 1'b0;
  logic          bus_write = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [N-1:0]  bus_wdata = '0;
  logic [N-1:0]  bus_rdata;
  logic [N-1:0]  pin_in = '0;
  logic [N-1:0]  pin_out;
  logic [N-1:0]  pin_oe;

  int n_vec = 0;
  int n_bad = 0;
  int cycles = 0;
  logic done = 1'b0;

  logic [N-1:0] m_out = '0;
  logic [N-1:0] m_dir = '0;
  logic [N-1:0] m_in  = '0;
  logic [31:0]  rng = 32'h1234_5678;

  always #5 clk = ~clk;

  gpio_port_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] next_rng(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  // Model update written arithmetically from the requirements.
  function automatic logic [N-1:0] model_out(input logic [N-1:0] cur, input int off,
                                             input logic [N-1:0] w);
    case (off)
      'h00: return w;
      'h04: return cur | w;
      'h08: return cur & ~w;
      'h0C: return cur ^ w;
      default: return cur;
    endcase
  endfunction

  task automatic wr(input int off, input logic [N-1:0] w);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = AW'(off); bus_wdata = w;
    #1 check("R9 rdata in write cycle", bus_rdata, '0);
    m_out = model_out(m_out, off, w);
    if (off == 'h14) m_dir = w;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    check("R2-5 pin_out after write", pin_out, m_out);
    check("R7 pin_oe after write", pin_oe, m_dir);
  endtask

  task automatic rd(input int off, input logic [N-1:0] exp, input string tag);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = AW'(off);
    #1 check(tag, bus_rdata, exp);
    bus_valid = 1'b0;
    #1 check("R9 rdata idle", bus_rdata, '0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        n_bad++;
        $display("FAIL watchdog actual=%0d expected<=100000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pin_out reset", pin_out, '0);
    check("R1 pin_oe reset", pin_oe, '0);
    rd('h00, '0, "R1 data reads zero");
    rd('h14, '0, "R1 dir reads zero");

    // R3 walking set, R2 readback
    for (int i = 0; i < N; i++) begin
      wr('h04, N'(1) << i);
      @(negedge clk);
      rd('h00, m_out, "R2 data readback after R3 set");
    end
    // R5 walking toggle on every other bit
    for (int i = 0; i < N; i += 2) wr('h0C, N'(1) << i);
    rd('h00, 32'hAAAA_AAAA, "R5 toggle pattern");
    // R4 walking clear
    for (int i = 0; i < N; i++) wr('h08, N'(1) << i);
    rd('h00, '0, "R4 clear all");

    // R2..R7 mixed random ops
    for (int k = 0; k < 200; k++) begin
      int op;
      rng = next_rng(rng);
      op = int'(rng % 5);
      rng = next_rng(rng);
      case (op)
        0: wr('h00, rng);
        1: wr('h04, rng);
        2: wr('h08, rng);
        3: wr('h0C, rng);
        default: wr('h14, rng);
      endcase
      rd('h00, m_out, "R2 random data readback");
      rd('h14, m_dir, "R7 random dir readback");
    end

    // R8 write-only and unmapped offsets
    wr('h00, 32'h5A5A_C3C3);
    rd('h04, '0, "R8 set reads zero");
    rd('h08, '0, "R8 clear reads zero");
    rd('h0C, '0, "R8 toggle reads zero");
    for (int a = 'h18; a < 256; a += 'h14) begin
      wr(a, 32'hFFFF_FFFF);
      rd(a, '0, "R8 unmapped reads zero");
    end
    wr('h05, 32'hFFFF_FFFF);
    wr('h02, 32'h0000_0000);
    check("R8 misaligned writes ignored", pin_out, 32'h5A5A_C3C3);
    rd('h01, '0, "R8 misaligned reads zero");

    // R6 input sync latency and write-ignore
    for (int k = 0; k < 24; k++) begin
      logic [N-1:0] prev;
      prev = m_in;
      rng = next_rng(rng);
      m_in = (k < 8) ? (N'(1) << (k * 4)) : rng;
      @(negedge clk);
      pin_in = m_in;
      @(negedge clk);
      rd('h10, prev, "R6 one edge later old value");
      @(negedge clk);
      rd('h10, m_in, "R6 two edges later new value");
    end
    wr('h10, ~m_in);
    @(negedge clk);
    rd('h10, m_in, "R6 input ignores writes");
    check("R6 write to input leaves pin_out", pin_out, m_out);
    check("R6 write to input leaves pin_oe", pin_oe, m_dir);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule